// File: doc/BRIEF.md
# Buck Converter Switch Sequencer with PWM/PFM Mode Control

This block drives the two power switches of a synchronous step-down converter. All analog sensing stays outside it: a modulator comparator, a peak-current comparator, a zero/reverse-current detector, an output-low comparator and an over-current comparator each hand it a single-bit flag. A periodic clock pulse sets the switching frequency. From these it produces the high-side and low-side gate commands, a light-load mode flag and a discontinuous-conduction flag.

At moderate and heavy load it runs fixed-frequency current-mode control. Each clock pulse opens a period with the high-side switch. The modulator trip hands conduction to the low-side switch. If the inductor current falls to zero before the next pulse, the low-side switch is released early. After a run of such discontinuous periods that lasts long enough, the block drops to pulse-on-demand operation. In that mode one fixed-peak pulse is fired each time the output sags. It goes back to fixed-frequency control when the output sags again while the previous pulse is still freewheeling. Every hand-over between the switches passes through a programmable gap in which both are off.

Top module: `buck_switch_ctrl`

## Requirements
- R1: In fixed-frequency mode (pfm_mode=0), a clk_pulse while the high side is off begins a period: the high side turns on after DEAD_TICKS cycles with both switches off. A clk_pulse while the high side is already on has no effect.
- R2: In fixed-frequency mode, mod_trip while the high side is on turns it off on the next cycle. After DEAD_TICKS cycles with both off, the low side turns on and stays on until the next clk_pulse.
- R3: In fixed-frequency mode, i_zero while the low side is on (and no clk_pulse in the same cycle) turns the low side off on the next cycle and raises dcm.
- R4: Once dcm has been high for DCM_HOLD_CYC consecutive cycles, pfm_mode rises and dcm falls in the same cycle. The switch state is unchanged.
- R5: A clk_pulse that ends a period with no zero-current event in it clears dcm, and restarts the hold count.
- R6: In pulse-on-demand mode (pfm_mode=1), a pulse starts only from the both-off idle state and only on vout_low. The high side turns on after DEAD_TICKS both-off cycles. clk_pulse has no effect.
- R7: In pulse-on-demand mode, peak_hit ends the high-side phase, and the low side follows after the dead gap. mod_trip has no effect.
- R8: In pulse-on-demand mode, i_zero while the low side is on turns it off, and both switches stay off until the next vout_low.
- R9: In pulse-on-demand mode, vout_low while the low side is on or in its dead gap clears pfm_mode on the next cycle. The low side keeps its state, and the following clk_pulse starts a fixed-frequency period.
- R10: When i_zero and vout_low arrive in the same cycle with the low side on, the zero event wins: the low side turns off and pfm_mode stays 1.
- R11: over_cur while the high side is on turns it off on the next cycle, in either mode.
- R12: The two switches are never on together. Either switch turns on only after at least DEAD_TICKS consecutive cycles with both off.
- R13: While rst_n is low or enable is low, both switches are off, pfm_mode is 0 and dcm is 0. On enable, the block waits in fixed-frequency mode with both off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces both switches off and fixed-frequency mode |
| clk_pulse | input | 1 | One-cycle period start pulse for fixed-frequency mode |
| mod_trip | input | 1 | Current-mode modulator tripped (fixed-frequency high-side end) |
| peak_hit | input | 1 | Preset peak current reached (pulse-on-demand high-side end) |
| i_zero | input | 1 | Inductor current at zero or reversing |
| vout_low | input | 1 | Output below nominal |
| over_cur | input | 1 | Over-current limit exceeded |
| hs_on | output | 1 | High-side switch command |
| ls_on | output | 1 | Low-side switch command |
| pfm_mode | output | 1 | 1 = pulse-on-demand mode, 0 = fixed-frequency mode |
| dcm | output | 1 | Discontinuous-conduction run in progress (fixed-frequency mode) |

## Verification
Fixed-frequency operation is tried with full continuous periods and with periods cut short by a zero-current event. This separates the low side held until the clock pulse from the low side released early. A run of discontinuous periods broken by one continuous period shows that the hold count restarts. A later unbroken run shows that the mode changes exactly at the hold limit. In pulse-on-demand mode, stray clock pulses and modulator trips check that the mode ignores them. A sag during freewheeling is set against a sag in the same cycle as the zero event, which tells apart the return path from the tie. Over-current is applied in both modes, and disabling mid-pulse checks the forced return to the safe state.

// File: rtl/buck_ctrl_pkg.sv
package buck_ctrl_pkg;

  // switch phases of one conduction cycle
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,  // both switches off, waiting
    PH_DEAD_HI = 3'd1,  // gap before high side
    PH_HI      = 3'd2,  // high side conducting
    PH_DEAD_LO = 3'd3,  // gap before low side
    PH_LO      = 3'd4   // low side conducting
  } sw_phase_t;

  // true on the last count of a span of 'span' cycles counted from zero
  function automatic logic at_last(input int unsigned cnt, input int unsigned span);
    return cnt == span - 1;
  endfunction

endpackage

// File: rtl/sw_phase_seq.sv
module sw_phase_seq
  import buck_ctrl_pkg::*;
#(
  parameter int unsigned DEAD_TICKS = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      go_hi,
  input  logic      cut_hi,
  input  logic      cut_lo,
  output sw_phase_t phase,
  output logic      hs_on,
  output logic      ls_on
);

  localparam int unsigned DW = (DEAD_TICKS > 1) ? $clog2(DEAD_TICKS) : 1;
  localparam int unsigned GW = DW + 1;

  logic [DW-1:0] dead_cnt;
  logic          dead_done;

  assign dead_done = at_last(32'(dead_cnt), DEAD_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      dead_cnt <= '0;
    end else if (!enable) begin
      phase    <= PH_IDLE;
      dead_cnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (go_hi) begin
            phase    <= PH_DEAD_HI;
            dead_cnt <= '0;
          end
        end
        PH_DEAD_HI: begin
          if (dead_done) phase <= PH_HI;
          else           dead_cnt <= dead_cnt + 1'b1;
        end
        PH_HI: begin
          if (cut_hi) begin
            phase    <= PH_DEAD_LO;
            dead_cnt <= '0;
          end
        end
        PH_DEAD_LO: begin
          if (go_hi) begin
            phase    <= PH_DEAD_HI;
            dead_cnt <= '0;
          end else if (dead_done) begin
            phase <= PH_LO;
          end else begin
            dead_cnt <= dead_cnt + 1'b1;
          end
        end
        PH_LO: begin
          if (go_hi) begin
            phase    <= PH_DEAD_HI;
            dead_cnt <= '0;
          end else if (cut_lo) begin
            phase <= PH_IDLE;
          end
        end
        default: begin
          phase    <= PH_IDLE;
          dead_cnt <= '0;
        end
      endcase
    end
  end

  assign hs_on = (phase == PH_HI);
  assign ls_on = (phase == PH_LO);

  // checker-side run length of both-off cycles, saturating at DEAD_TICKS
  logic [GW-1:0] off_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                off_run <= '0;
    else if (hs_on || ls_on)   off_run <= '0;
    else if (32'(off_run) < DEAD_TICKS) off_run <= off_run + 1'b1;
  end

  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  assert_dead_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_on) || $rose(ls_on)) |-> (32'(off_run) >= DEAD_TICKS));

endmodule

// File: rtl/dcm_run_tracker.sv
module dcm_run_tracker
  import buck_ctrl_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 5500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,      // fixed-frequency mode and enabled
  input  logic zero_evt,    // low side released early by zero current
  input  logic period_end,  // clock pulse closing a period
  output logic streak,
  output logic hold_done
);

  localparam int unsigned HW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;

  logic [HW-1:0] run_cnt;
  logic          per_zero;   // zero event seen in the running period
  logic          breaks;

  assign hold_done = streak && at_last(32'(run_cnt), HOLD_CYC);
  assign breaks    = period_end && !per_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak   <= 1'b0;
      per_zero <= 1'b0;
      run_cnt  <= '0;
    end else if (!active || hold_done) begin
      streak   <= 1'b0;
      per_zero <= 1'b0;
      run_cnt  <= '0;
    end else begin
      run_cnt <= (streak && !breaks) ? run_cnt + 1'b1 : '0;
      if (zero_evt) begin
        streak   <= 1'b1;
        per_zero <= 1'b1;
      end else if (period_end) begin
        per_zero <= 1'b0;
        if (!per_zero) streak <= 1'b0;
      end
    end
  end

  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !streak |=> (run_cnt == '0) || streak);

endmodule

// File: rtl/buck_switch_ctrl.sv
module buck_switch_ctrl #(
  parameter int unsigned DEAD_TICKS   = 2,
  parameter int unsigned DCM_HOLD_CYC = 5500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clk_pulse,
  input  logic mod_trip,
  input  logic peak_hit,
  input  logic i_zero,
  input  logic vout_low,
  input  logic over_cur,
  output logic hs_on,
  output logic ls_on,
  output logic pfm_mode,
  output logic dcm
);

  import buck_ctrl_pkg::*;

  sw_phase_t phase;
  logic      go_hi, cut_hi, cut_lo;
  logic      ph_idle, ph_lo, ph_lo_side;
  logic      zero_evt, period_end, hold_done, ret_pwm;
  logic      pfm_q;

  assign ph_idle    = (phase == PH_IDLE);
  assign ph_lo      = (phase == PH_LO);
  assign ph_lo_side = ph_lo || (phase == PH_DEAD_LO);

  // request decode per mode
  assign go_hi  = pfm_q ? (vout_low && ph_idle) : clk_pulse;
  assign cut_hi = (pfm_q ? peak_hit : mod_trip) || over_cur;
  assign cut_lo = i_zero;

  // fixed-frequency bookkeeping events
  assign zero_evt   = !pfm_q && ph_lo && i_zero && !clk_pulse;
  assign period_end = !pfm_q && clk_pulse && (ph_idle || ph_lo_side);

  // sag during freewheel, unless the zero event lands in the same cycle
  assign ret_pwm = pfm_q && vout_low && ph_lo_side && !(ph_lo && i_zero);

  sw_phase_seq #(.DEAD_TICKS(DEAD_TICKS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .go_hi  (go_hi),
    .cut_hi (cut_hi),
    .cut_lo (cut_lo),
    .phase  (phase),
    .hs_on  (hs_on),
    .ls_on  (ls_on)
  );

  dcm_run_tracker #(.HOLD_CYC(DCM_HOLD_CYC)) u_dcm (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (enable && !pfm_q),
    .zero_evt   (zero_evt),
    .period_end (period_end),
    .streak     (dcm),
    .hold_done  (hold_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pfm_q <= 1'b0;
    else if (!enable)   pfm_q <= 1'b0;
    else if (hold_done) pfm_q <= 1'b1;
    else if (ret_pwm)   pfm_q <= 1'b0;
  end

  assign pfm_mode = pfm_q;

  assert_oc_cut_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_on && over_cur) |=> !hs_on);

  assert_pfm_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfm_mode) |-> $past(dcm));

  assert_pwm_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pfm_mode) |-> ($past(vout_low) || !$past(enable)));

  assert_disable_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hs_on && !ls_on && !pfm_mode && !dcm));

endmodule

// File: tb/buck_switch_ctrl_bench.sv
module buck_switch_ctrl_bench;

  localparam int unsigned DEAD = 2;
  localparam int unsigned HOLD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic clk_pulse = 1'b0, mod_trip = 1'b0, peak_hit = 1'b0;
  logic i_zero = 1'b0, vout_low = 1'b0, over_cur = 1'b0;
  logic hs_on, ls_on, pfm_mode, dcm;

  always #2 clk = ~clk;  // 250 MHz

  buck_switch_ctrl #(.DEAD_TICKS(DEAD), .DCM_HOLD_CYC(HOLD)) u_buck_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .clk_pulse(clk_pulse), .mod_trip(mod_trip), .peak_hit(peak_hit),
    .i_zero(i_zero), .vout_low(vout_low), .over_cur(over_cur),
    .hs_on(hs_on), .ls_on(ls_on), .pfm_mode(pfm_mode), .dcm(dcm)
  );

  typedef struct {
    string tag;
    logic  hs, ls, pfm, dc;
  } exp_t;

  exp_t sb[$];
  exp_t item;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  // driver side: one clock of stimulus, then the post-edge state is ready
  task automatic tick(input bit cp, input bit mt, input bit pk,
                      input bit iz, input bit vl, input bit oc);
    @(negedge clk);
    clk_pulse = cp; mod_trip = mt; peak_hit = pk;
    i_zero = iz; vout_low = vl; over_cur = oc;
    @(posedge clk);
    #1;
    clk_pulse = 0; mod_trip = 0; peak_hit = 0;
    i_zero = 0; vout_low = 0; over_cur = 0;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0);
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    enable = v;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input bit hs, input bit ls,
                            input bit pfm, input bit dc);
    exp_t e;
    e.tag = tag; e.hs = hs; e.ls = ls; e.pfm = pfm; e.dc = dc;
    sb.push_back(e);
  endtask

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item = sb.pop_front();
        n_chk++;
        if (hs_on !== item.hs || ls_on !== item.ls ||
            pfm_mode !== item.pfm || dcm !== item.dc) begin
          n_err++;
          $display("FAIL %s: actual hs=%0d ls=%0d pfm=%0d dcm=%0d expected hs=%0d ls=%0d pfm=%0d dcm=%0d",
                   item.tag, hs_on, ls_on, pfm_mode, dcm,
                   item.hs, item.ls, item.pfm, item.dc);
        end
      end
    end
  end

  // run the bench through the mode switch to pulse-on-demand, expecting it at HOLD
  task automatic enter_pfm(input string tag);
    tick(1, 0, 0, 0, 0, 0); quiet(2);       // high side on
    tick(0, 1, 0, 0, 0, 0); quiet(2);       // low side on
    tick(0, 0, 0, 1, 0, 0);                 // zero event, streak starts
    quiet(HOLD - 1);
    expect_out({tag, " R4 one cycle short of hold"}, 0, 0, 0, 1);
    quiet(1);
    expect_out({tag, " R4 mode change at hold"}, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    expect_out("R13 reset state", 0, 0, 0, 0);

    set_en(1);
    quiet(1);
    expect_out("R13 enabled idle in fixed-frequency mode", 0, 0, 0, 0);

    // R1: period start with dead gap
    tick(1, 0, 0, 0, 0, 0);
    expect_out("R12 first dead cycle", 0, 0, 0, 0);
    quiet(1);
    expect_out("R12 second dead cycle", 0, 0, 0, 0);
    quiet(1);
    expect_out("R1 high side on after gap", 1, 0, 0, 0);
    tick(1, 0, 0, 0, 0, 0);
    expect_out("R1 pulse during high side ignored", 1, 0, 0, 0);

    // R2: trip hands over to low side, held until next pulse
    tick(0, 1, 0, 0, 0, 0);
    expect_out("R2 high side off after trip", 0, 0, 0, 0);
    quiet(2);
    expect_out("R2 low side on after gap", 0, 1, 0, 0);
    quiet(3);
    expect_out("R2 low side held", 0, 1, 0, 0);
    tick(1, 0, 0, 0, 0, 0);
    expect_out("R1 continuous period ends at pulse", 0, 0, 0, 0);
    quiet(2);
    expect_out("R1 next high side", 1, 0, 0, 0);

    // R3 / R5: discontinuous period, then a continuous one breaks the run
    tick(0, 1, 0, 0, 0, 0); quiet(2);
    tick(0, 0, 0, 1, 0, 0);
    expect_out("R3 zero current releases low side", 0, 0, 0, 1);
    tick(1, 0, 0, 0, 0, 0);
    expect_out("R5 run kept over a discontinuous period end", 0, 0, 0, 1);
    quiet(2);
    tick(0, 1, 0, 0, 0, 0); quiet(2);
    expect_out("R2 low side on in second period", 0, 1, 0, 1);
    tick(1, 0, 0, 0, 0, 0);
    expect_out("R5 continuous period clears run", 0, 0, 0, 0);
    quiet(2);
    expect_out("R1 high side after break", 1, 0, 0, 0);

    // R4: unbroken run reaches the hold limit
    tick(0, 1, 0, 0, 0, 0); quiet(2);
    tick(0, 0, 0, 1, 0, 0);
    quiet(HOLD - 1);
    expect_out("R4 one cycle short of hold", 0, 0, 0, 1);
    quiet(1);
    expect_out("R4 mode change at hold", 0, 0, 1, 0);

    // R6 / R7 / R8: pulse on demand
    tick(1, 0, 0, 0, 0, 0);
    expect_out("R6 clock pulse ignored", 0, 0, 1, 0);
    tick(0, 0, 0, 0, 1, 0);
    expect_out("R6 demand enters gap", 0, 0, 1, 0);
    quiet(2);
    expect_out("R6 high side on after gap", 1, 0, 1, 0);
    tick(0, 1, 0, 0, 0, 0);
    expect_out("R7 modulator trip ignored", 1, 0, 1, 0);
    tick(0, 0, 1, 0, 0, 0);
    expect_out("R7 peak ends high side", 0, 0, 1, 0);
    quiet(2);
    expect_out("R7 low side after gap", 0, 1, 1, 0);
    tick(0, 0, 0, 1, 0, 0);
    expect_out("R8 zero current idles both", 0, 0, 1, 0);
    quiet(2);
    expect_out("R8 idle until demand", 0, 0, 1, 0);

    // R10: sag and zero in the same cycle
    tick(0, 0, 0, 0, 1, 0); quiet(2);
    tick(0, 0, 1, 0, 0, 0); quiet(2);
    tick(0, 0, 0, 1, 1, 0);
    expect_out("R10 zero wins over sag", 0, 0, 1, 0);

    // R11 in pulse-on-demand mode
    tick(0, 0, 0, 0, 1, 0); quiet(2);
    tick(0, 0, 0, 0, 0, 1);
    expect_out("R11 over-current cuts high side", 0, 0, 1, 0);
    quiet(2);
    expect_out("R11 low side follows", 0, 1, 1, 0);
    tick(0, 0, 0, 1, 0, 0);

    // R13: disable mid pulse
    tick(0, 0, 0, 0, 1, 0); quiet(2);
    expect_out("R6 high side before disable", 1, 0, 1, 0);
    set_en(0);
    expect_out("R13 disable forces off", 0, 0, 0, 0);
    set_en(1);
    quiet(1);
    expect_out("R13 re-enabled idle", 0, 0, 0, 0);

    // R9: sag while freewheeling returns to fixed-frequency mode
    enter_pfm("second entry");
    tick(0, 0, 0, 0, 1, 0); quiet(2);
    tick(0, 0, 1, 0, 0, 0); quiet(2);
    expect_out("R7 low side freewheeling", 0, 1, 1, 0);
    tick(0, 0, 0, 0, 1, 0);
    expect_out("R9 sag during freewheel leaves mode", 0, 1, 0, 0);
    tick(1, 0, 0, 0, 0, 0);
    expect_out("R9 clock pulse starts period", 0, 0, 0, 0);
    quiet(2);
    expect_out("R9 high side in fixed-frequency mode", 1, 0, 0, 0);

    // R11 in fixed-frequency mode
    tick(0, 0, 0, 0, 0, 1);
    expect_out("R11 over-current in fixed-frequency mode", 0, 0, 0, 0);
    quiet(2);
    expect_out("R11 low side after gap", 0, 1, 0, 0);

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R13: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule